// File: doc/BRIEF.md
# Bit-Addressable General-Purpose I/O Port

This block is one 8-bit general-purpose I/O port. It keeps three registers: a direction register, an output register whose bits double as pull-up enables on input pins, and a read-only pin register. The pin register holds the pad levels after they have passed through a two-flop synchroniser. From the direction and output bits, each pin takes one of four modes: high impedance, pulled up, driving 0 or driving 1. The port reports each pin's mode on three per-pin outputs: a drive enable, a drive value and a pull-up enable.

Software reaches the port in two ways. The first is byte reads and writes on an I/O register bus. The second is 16-bit single-bit instruction words, which the block decodes itself. Set and clear words change one bit of the direction or output register and leave every other bit alone. The two test words raise a skip indication in the same cycle when the named bit meets the stated condition. A core uses this indication to skip its next instruction. The three registers take three consecutive I/O addresses starting at a base address parameter: pin register, then direction, then output.

Top module: `gpio_bitport`

## Requirements
- R1: After a synchronous reset the direction and output registers read 0x00, and every pin reports drive enable 0, drive value 0 and pull-up 0.
- R2: A byte write to BASE+1 loads the direction register and a byte write to BASE+2 loads the output register. `bus_rdata` returns the pin register at BASE, direction at BASE+1 and output at BASE+2, and returns 0x00 at every other address. With the default BASE of 0x16, these addresses are 0x16, 0x17 and 0x18.
- R3: The pin register is read-only. A byte write to BASE changes no register.
- R4: A new level on `pad_in` is visible in the pin register after the second rising clock edge, and not after the first.
- R5: Per pin: direction 1 gives drive enable 1, drive value equal to the output bit, and pull-up 0. Direction 0 gives drive enable 0, drive value 0, and pull-up equal to the output bit.
- R6: Word layout: bits 15..10 = 100110, bits 9..8 = operation, bits 7..3 = I/O address, bits 2..0 = bit number. Operation 10 (set, 0x9A00 | addr<<3 | bit) sets only the named bit of the direction or output register.
- R7: Operation 00 (clear, 0x9800 | addr<<3 | bit) clears only the named bit of the direction or output register.
- R8: Operation 01 (skip-if-clear, 0x9900 | addr<<3 | bit) drives `skip` high in the same cycle that `instr_valid` is high and the named bit of the addressed register (pin, direction or output) is 0. Otherwise `skip` is low.
- R9: Operation 11 (skip-if-set, 0x9B00 | addr<<3 | bit) drives `skip` high in the same cycle when the named bit is 1, and low otherwise.
- R10: The following words change no register and leave `skip` low: a word whose address is not one of the port's three, a word whose upper six bits are not 100110, and any word while `instr_valid` is low. A set or clear aimed at the pin register changes nothing.
- R11: If a byte write and a set or clear hit the same register in the same cycle, the bit operation is applied to the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | I/O register address for byte access |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Byte write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| instr_valid | input | 1 | Qualifies `instr_word` |
| instr_word | input | 16 | Single-bit instruction word |
| skip | output | 1 | Bit test met its condition (combinational) |
| pad_in | input | 8 | Asynchronous pin levels |
| pad_oe | output | 8 | Per-pin drive enable |
| pad_out | output | 8 | Per-pin drive value |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
The block's outputs fall into three timing groups. `skip` and `bus_rdata` are combinational, so they are sampled one time step after their inputs are driven, while those inputs are still held. Byte writes and set or clear words take effect at the next rising edge, so the register or pad output is read at the falling edge that follows. A pad level is checked twice: after one rising edge, when the old value must still be present, and after a second edge, when the new value must appear. This shows the two-cycle synchroniser delay exactly and rules out a one-cycle design. All inputs change only at falling edges, so no check depends on the order in which processes run at a rising edge.

// File: rtl/gpio_bitport_pkg.sv
package gpio_bitport_pkg;

    localparam int PORT_W   = 8;
    localparam int IO_AW    = 6;
    localparam int INSTR_W  = 16;
    localparam int BITSEL_W = 3;
    localparam int LOW_AW   = 5;

    localparam logic [5:0] BITOP_PREFIX = 6'b100110;

    typedef enum logic [1:0] {
        BOP_CLR   = 2'b00,
        BOP_SKIPC = 2'b01,
        BOP_SET   = 2'b10,
        BOP_SKIPS = 2'b11
    } bitop_e;

    typedef enum logic [1:0] {
        REG_PIN  = 2'd0,
        REG_DIR  = 2'd1,
        REG_OUT  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PIN_HIZ    = 2'd0,
        PIN_PULLUP = 2'd1,
        PIN_DRV0   = 2'd2,
        PIN_DRV1   = 2'd3
    } pin_mode_e;

    typedef struct packed {
        logic                  hit;
        bitop_e                op;
        logic [LOW_AW-1:0]     addr;
        logic [BITSEL_W-1:0]   bsel;
    } bitop_t;

    function automatic bitop_t decode_bitop(input logic v, input logic [INSTR_W-1:0] w);
        bitop_t r;
        r.hit  = v && (w[15:10] == BITOP_PREFIX);
        r.op   = bitop_e'(w[9:8]);
        r.addr = w[7:3];
        r.bsel = w[2:0];
        return r;
    endfunction

    function automatic pin_mode_e mode_of(input logic dir_b, input logic out_b);
        pin_mode_e m;
        case ({dir_b, out_b})
            2'b00:   m = PIN_HIZ;
            2'b01:   m = PIN_PULLUP;
            2'b10:   m = PIN_DRV0;
            default: m = PIN_DRV1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/gpio_bitop_decode.sv
module gpio_bitop_decode
    import gpio_bitport_pkg::*;
#(
    parameter logic [IO_AW-1:0] BASE = 6'h16
) (
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr_word,
    output bitop_t             bop,
    output reg_sel_e           tgt
);
    localparam logic [IO_AW-1:0] A_PIN = BASE;
    localparam logic [IO_AW-1:0] A_DIR = BASE + 1;
    localparam logic [IO_AW-1:0] A_OUT = BASE + 2;

    logic [IO_AW-1:0] addr_ext;

    always_comb begin
        bop      = decode_bitop(instr_valid, instr_word);
        addr_ext = {1'b0, bop.addr};
        if (!bop.hit)              tgt = REG_NONE;
        else if (addr_ext == A_PIN) tgt = REG_PIN;
        else if (addr_ext == A_DIR) tgt = REG_DIR;
        else if (addr_ext == A_OUT) tgt = REG_OUT;
        else                        tgt = REG_NONE;
    end
endmodule

// File: rtl/gpio_pin_mode.sv
module gpio_pin_mode
    import gpio_bitport_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] dir_bits,
    input  logic [W-1:0] out_bits,
    output logic [W-1:0] oe,
    output logic [W-1:0] drv,
    output logic [W-1:0] pu
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_mode_e mode;
        assign mode   = mode_of(dir_bits[i], out_bits[i]);
        assign oe[i]  = (mode == PIN_DRV0) || (mode == PIN_DRV1);
        assign drv[i] = (mode == PIN_DRV1);
        assign pu[i]  = (mode == PIN_PULLUP);
    end
endmodule

// File: rtl/gpio_bitport.sv
module gpio_bitport
    import gpio_bitport_pkg::*;
#(
    parameter logic [IO_AW-1:0] BASE = 6'h16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IO_AW-1:0]   bus_addr,
    input  logic               bus_wr,
    input  logic [PORT_W-1:0]  bus_wdata,
    output logic [PORT_W-1:0]  bus_rdata,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr_word,
    output logic               skip,
    input  logic [PORT_W-1:0]  pad_in,
    output logic [PORT_W-1:0]  pad_oe,
    output logic [PORT_W-1:0]  pad_out,
    output logic [PORT_W-1:0]  pad_pu
);
    localparam logic [IO_AW-1:0] A_PIN = BASE;
    localparam logic [IO_AW-1:0] A_DIR = BASE + 1;
    localparam logic [IO_AW-1:0] A_OUT = BASE + 2;

    logic [PORT_W-1:0] dir_q, dir_n;
    logic [PORT_W-1:0] out_q, out_n;
    logic [PORT_W-1:0] pin_q;
    logic [PORT_W-1:0] bit_mask;
    logic [PORT_W-1:0] tested_reg;
    bitop_t            bop;
    reg_sel_e          bop_tgt;
    reg_sel_e          bus_tgt;
    logic              is_skip_op;

    gpio_sync2 #(.W(PORT_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_q)
    );

    gpio_bitop_decode #(.BASE(BASE)) u_dec (
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .bop         (bop),
        .tgt         (bop_tgt)
    );

    gpio_pin_mode #(.W(PORT_W)) u_mode (
        .dir_bits (dir_q),
        .out_bits (out_q),
        .oe       (pad_oe),
        .drv      (pad_out),
        .pu       (pad_pu)
    );

    always_comb begin
        if (bus_addr == A_PIN)      bus_tgt = REG_PIN;
        else if (bus_addr == A_DIR) bus_tgt = REG_DIR;
        else if (bus_addr == A_OUT) bus_tgt = REG_OUT;
        else                        bus_tgt = REG_NONE;
    end

    assign bit_mask = PORT_W'(1) << bop.bsel;

    // Next state: byte write first, then the single-bit operation on top.
    always_comb begin
        dir_n = dir_q;
        out_n = out_q;
        if (bus_wr && bus_tgt == REG_DIR) dir_n = bus_wdata;
        if (bus_wr && bus_tgt == REG_OUT) out_n = bus_wdata;
        if (bop_tgt == REG_DIR) begin
            if (bop.op == BOP_SET) dir_n = dir_n | bit_mask;
            if (bop.op == BOP_CLR) dir_n = dir_n & ~bit_mask;
        end
        if (bop_tgt == REG_OUT) begin
            if (bop.op == BOP_SET) out_n = out_n | bit_mask;
            if (bop.op == BOP_CLR) out_n = out_n & ~bit_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            out_q <= '0;
        end else begin
            dir_q <= dir_n;
            out_q <= out_n;
        end
    end

    always_comb begin
        case (bop_tgt)
            REG_PIN: tested_reg = pin_q;
            REG_DIR: tested_reg = dir_q;
            REG_OUT: tested_reg = out_q;
            default: tested_reg = '0;
        endcase
    end

    assign is_skip_op = (bop.op == BOP_SKIPC) || (bop.op == BOP_SKIPS);
    // op[1] is the bit level that satisfies the test (01 -> 0, 11 -> 1)
    assign skip = (bop_tgt != REG_NONE) && is_skip_op
                  && (tested_reg[bop.bsel] == bop.op[1]);

    always_comb begin
        case (bus_tgt)
            REG_PIN: bus_rdata = pin_q;
            REG_DIR: bus_rdata = dir_q;
            REG_OUT: bus_rdata = out_q;
            default: bus_rdata = '0;
        endcase
    end

    // ---------------- assertions ----------------
    logic [1:0] rst_age;
    always_ff @(posedge clk) begin
        if (rst)               rst_age <= 2'd0;
        else if (rst_age != 2'd2) rst_age <= rst_age + 2'd1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dir_q == '0 && out_q == '0));

    assert_sync_latency_R4: assert property (@(posedge clk) disable iff (rst)
        (rst_age == 2'd2) |-> (pin_q == $past(pad_in, 2)));

    assert_set_only_bit_R6: assert property (@(posedge clk) disable iff (rst)
        (bop_tgt == REG_OUT && bop.op == BOP_SET && !(bus_wr && bus_tgt == REG_OUT))
        |=> (out_q == ($past(out_q) | $past(bit_mask))));

    assert_clr_only_bit_R7: assert property (@(posedge clk) disable iff (rst)
        (bop_tgt == REG_DIR && bop.op == BOP_CLR && !(bus_wr && bus_tgt == REG_DIR))
        |=> (dir_q == ($past(dir_q) & ~$past(bit_mask))));

    assert_skip_qualified_R10: assert property (@(posedge clk) disable iff (rst)
        skip |-> instr_valid);
endmodule

// File: tb/gpio_bitport_bench.sv
module gpio_bitport_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        instr_valid;
    logic [15:0] instr_word;
    logic        skip;
    logic [7:0]  pad_in;
    logic [7:0]  pad_oe;
    logic [7:0]  pad_out;
    logic [7:0]  pad_pu;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [5:0] A_PIN = 6'h16;
    localparam logic [5:0] A_DIR = 6'h17;
    localparam logic [5:0] A_OUT = 6'h18;
    localparam logic [5:0] A_IDLE = 6'h00;

    always #10 clk = ~clk;

    gpio_bitport u_gpio_bitport (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .instr_valid(instr_valid), .instr_word(instr_word), .skip(skip),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [1:0] op, input logic [4:0] a, input logic [2:0] b);
        return {6'b100110, op, a, b};
    endfunction

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = A_IDLE;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = A_IDLE;
    endtask

    // Issue one instruction word for one cycle; returns skip seen during it.
    task automatic issue(input logic [15:0] w, output logic sk);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = w;
        #1;
        sk = skip;
        @(negedge clk);
        instr_valid = 1'b0; instr_word = 16'h0000;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        bus_read(A_DIR, d); chk("R1 dir after reset", 16'(d), 16'h00);
        bus_read(A_OUT, d); chk("R1 out after reset", 16'(d), 16'h00);
        chk("R1 pads after reset", {pad_oe, pad_out | pad_pu}, 16'h0000);
    endtask

    task automatic t_byte_rw;
        logic [7:0] d;
        bus_write(A_DIR, 8'h3C);
        bus_write(A_OUT, 8'hA5);
        bus_read(A_DIR, d); chk("R2 dir readback", 16'(d), 16'h3C);
        bus_read(A_OUT, d); chk("R2 out readback", 16'(d), 16'hA5);
        bus_read(6'h19, d); chk("R2 unmapped read", 16'(d), 16'h00);
    endtask

    task automatic t_pin_readonly;
        logic [7:0] d;
        pad_in = 8'h5A;
        repeat (3) @(negedge clk);
        bus_write(A_PIN, 8'hFF);
        bus_read(A_PIN, d); chk("R3 pin write ignored", 16'(d), 16'h5A);
        bus_read(A_DIR, d); chk("R3 dir untouched", 16'(d), 16'h3C);
        bus_read(A_OUT, d); chk("R3 out untouched", 16'(d), 16'hA5);
    endtask

    task automatic t_sync;
        logic [7:0] d;
        @(negedge clk);
        pad_in = 8'hC3;
        @(negedge clk);
        bus_read(A_PIN, d); chk("R4 after one edge", 16'(d), 16'h5A);
        @(negedge clk);
        bus_read(A_PIN, d); chk("R4 after two edges", 16'(d), 16'hC3);
    endtask

    task automatic t_modes;
        bus_write(A_DIR, 8'hF0);
        bus_write(A_OUT, 8'hAA);
        chk("R5 drive enable", 16'(pad_oe), 16'hF0);
        chk("R5 drive value", 16'(pad_out), 16'hA0);
        chk("R5 pull-up", 16'(pad_pu), 16'h0A);
    endtask

    task automatic t_set;
        logic [7:0] d; logic sk;
        issue(mk(2'b10, 5'h18, 3'd0), sk);
        bus_read(A_OUT, d); chk("R6 set out bit0", 16'(d), 16'hAB);
        issue(mk(2'b10, 5'h17, 3'd2), sk);
        bus_read(A_DIR, d); chk("R6 set dir bit2", 16'(d), 16'hF4);
        chk("R6 set no skip", 16'(sk), 16'h0);
    endtask

    task automatic t_clear;
        logic [7:0] d; logic sk;
        issue(mk(2'b00, 5'h18, 3'd7), sk);
        bus_read(A_OUT, d); chk("R7 clear out bit7", 16'(d), 16'h2B);
        issue(mk(2'b00, 5'h17, 3'd4), sk);
        bus_read(A_DIR, d); chk("R7 clear dir bit4", 16'(d), 16'hE4);
    endtask

    task automatic t_skip_clear;
        logic sk;
        // pin = C3: bit2 is 0, bit0 is 1
        issue(mk(2'b01, 5'h16, 3'd2), sk); chk("R8 skipc pin bit clear", 16'(sk), 16'h1);
        issue(mk(2'b01, 5'h16, 3'd0), sk); chk("R8 skipc pin bit set", 16'(sk), 16'h0);
        issue(mk(2'b01, 5'h17, 3'd4), sk); chk("R8 skipc dir bit4", 16'(sk), 16'h1);
    endtask

    task automatic t_skip_set;
        logic sk;
        issue(mk(2'b11, 5'h16, 3'd7), sk); chk("R9 skips pin bit7", 16'(sk), 16'h1);
        issue(mk(2'b11, 5'h18, 3'd7), sk); chk("R9 skips out bit7 clear", 16'(sk), 16'h0);
        issue(mk(2'b11, 5'h18, 3'd5), sk); chk("R9 skips out bit5", 16'(sk), 16'h1);
    endtask

    task automatic t_foreign;
        logic [7:0] d; logic sk;
        issue(mk(2'b10, 5'h10, 3'd6), sk);
        bus_read(A_OUT, d); chk("R10 foreign addr out", 16'(d), 16'h2B);
        bus_read(A_DIR, d); chk("R10 foreign addr dir", 16'(d), 16'hE4);
        issue(16'h9CC6, sk);
        bus_read(A_OUT, d); chk("R10 bad prefix no change", 16'(d), 16'h2B);
        issue(mk(2'b11, 5'h10, 3'd0), sk); chk("R10 foreign skip low", 16'(sk), 16'h0);
        issue(mk(2'b00, 5'h16, 3'd7), sk);
        bus_read(A_PIN, d); chk("R10 clear on pin ignored", 16'(d), 16'hC3);
        @(negedge clk);
        instr_valid = 1'b0; instr_word = mk(2'b01, 5'h16, 3'd2);
        #1; chk("R10 invalid word no skip", 16'(skip), 16'h0);
        @(negedge clk);
        instr_word = mk(2'b10, 5'h18, 3'd6);
        @(negedge clk);
        instr_word = 16'h0000;
        bus_read(A_OUT, d); chk("R10 invalid word no set", 16'(d), 16'h2B);
    endtask

    task automatic t_collision;
        logic [7:0] d;
        @(negedge clk);
        bus_addr = A_DIR; bus_wr = 1'b1; bus_wdata = 8'h00;
        instr_valid = 1'b1; instr_word = mk(2'b10, 5'h17, 3'd3);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = A_IDLE; instr_valid = 1'b0; instr_word = 16'h0;
        bus_read(A_DIR, d); chk("R11 write plus set", 16'(d), 16'h08);
        @(negedge clk);
        bus_addr = A_OUT; bus_wr = 1'b1; bus_wdata = 8'hFF;
        instr_valid = 1'b1; instr_word = mk(2'b00, 5'h18, 3'd1);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = A_IDLE; instr_valid = 1'b0; instr_word = 16'h0;
        bus_read(A_OUT, d); chk("R11 write plus clear", 16'(d), 16'hFD);
    endtask

    initial begin
        rst = 1'b1; bus_addr = A_IDLE; bus_wr = 1'b0; bus_wdata = 8'h00;
        instr_valid = 1'b0; instr_word = 16'h0000; pad_in = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_byte_rw();
        t_pin_readonly();
        t_sync();
        t_modes();
        t_set();
        t_clear();
        t_skip_clear();
        t_skip_set();
        t_foreign();
        t_collision();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule